// File: doc/BRIEF.md
# Ripple Bit-Slice Integer ALU

This block is a purely combinational integer arithmetic and logic unit built from one-bit slices. Two operands and a four-bit operation code go in. The result, a carry-out, a signed-overflow flag and a zero flag come out in the same cycle. A datapath uses it for address arithmetic, comparison and the basic logical operations. It places its own register stages around the block.

The operation code is split into fields that drive every slice. Bit 3 inverts operand A. Bit 2 inverts operand B and also feeds the carry into bit 0. Bits 1:0 choose which value each slice outputs: the AND path, the OR path, the adder sum or the "less" input. NOR and subtraction reuse the AND path and the adder through these inversions. Set-less-than takes the sign of the subtraction from the top slice, corrects it with the overflow, and routes it back into bit 0.

There is no state, so no states or transitions exist. The house layout is kept in three layers: a decoder, the generated slices, and a flag stage.

Top module: `bitslice_alu`

## Requirements
- R1: Code 4'b0000 gives A AND B and code 4'b0001 gives A OR B. For both codes, carry-out and overflow are 0.
- R2: Code 4'b1100 gives NOT(A OR B). Carry-out and overflow are 0.
- R3: Code 4'b0010 gives the sum A+B modulo 2^32. Carry-out is bit 32 of the unsigned 33-bit sum.
- R4: Under code 4'b0010, overflow is 1 exactly when A[31] equals B[31] and the sum's bit 31 differs from A[31].
- R5: Code 4'b0110 gives A-B modulo 2^32, computed as A + ~B + 1. Carry-out is 1 exactly when A >= B as unsigned numbers. Overflow is 1 exactly when A[31] differs from B[31] and the difference's bit 31 differs from A[31].
- R6: Code 4'b0111 gives 1 when A < B as signed two's-complement numbers and 0 otherwise. Bits 31:1 are always 0. The comparison is correct even when A-B overflows.
- R7: Under code 4'b0111, carry-out and overflow take the same values as under code 4'b0110 for the same operands.
- R8: The zero flag is 1 exactly when all 32 result bits are 0. This holds for every code.
- R9: Any code other than the six above gives a result of 0, overflow 0 and carry-out 0. The zero flag is therefore 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | Carry out of the top slice (arithmetic codes only) |
| ovf_o | output | 1 | Signed overflow (arithmetic codes only) |
| zero_o | output | 1 | Result is all zeros |

## Verification
Every output is combinational and is due in the same cycle its inputs are applied; no output has any clock latency. The bench changes operands and code just after a rising edge. It reads all four outputs half a period later, at the falling edge, so the ripple chain has settled before any comparison. Corner operands cover these cases:
- overflow in both directions for add and for subtract;
- less-than comparisons whose subtraction overflows;
- the unsigned borrow boundary;
- every undefined code.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } alu_sel_e;

    localparam logic [OP_W-1:0] OPC_AND = 4'b0000;
    localparam logic [OP_W-1:0] OPC_OR  = 4'b0001;
    localparam logic [OP_W-1:0] OPC_ADD = 4'b0010;
    localparam logic [OP_W-1:0] OPC_SUB = 4'b0110;
    localparam logic [OP_W-1:0] OPC_SLT = 4'b0111;
    localparam logic [OP_W-1:0] OPC_NOR = 4'b1100;

    typedef struct packed {
        logic     valid;
        logic     arith;
        logic     ainv;
        logic     bneg;
        alu_sel_e sel;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
    import alu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output alu_ctrl_t       ctrl_o
);

    logic known;
    logic arith;

    always_comb begin
        known = 1'b1;
        arith = 1'b0;
        unique case (op_i)
            OPC_AND, OPC_OR, OPC_NOR: arith = 1'b0;
            OPC_ADD, OPC_SUB, OPC_SLT: arith = 1'b1;
            default: begin
                known = 1'b0;
                arith = 1'b0;
            end
        endcase
    end

    always_comb begin
        ctrl_o.valid = known;
        ctrl_o.arith = arith;
        ctrl_o.ainv  = known & op_i[3];
        ctrl_o.bneg  = known & op_i[2];
        ctrl_o.sel   = known ? alu_sel_e'(op_i[1:0]) : SEL_AND;
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     ainv_i,
    input  logic     bneg_i,
    input  alu_sel_e sel_i,
    input  logic     cin_i,
    input  logic     less_i,
    output logic     res_o,
    output logic     sum_o,
    output logic     cout_o
);

    logic a_eff;
    logic b_eff;

    assign a_eff  = a_i ^ ainv_i;
    assign b_eff  = b_i ^ bneg_i;
    assign sum_o  = a_eff ^ b_eff ^ cin_i;
    assign cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);

    always_comb begin
        unique case (sel_i)
            SEL_AND:  res_o = a_eff & b_eff;
            SEL_OR:   res_o = a_eff | b_eff;
            SEL_SUM:  res_o = sum_o;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_ctrl_t        ctrl_i,
    input  logic [WIDTH-1:0] bits_i,
    input  logic             top_cin_i,
    input  logic             top_cout_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o
);

    logic arith_ok;

    assign arith_ok = ctrl_i.valid & ctrl_i.arith;

    always_comb begin
        result_o = ctrl_i.valid ? bits_i : '0;
        carry_o  = arith_ok & top_cout_i;
        ovf_o    = arith_ok & (top_cin_i ^ top_cout_i);
        zero_o   = ~|result_o;
    end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctl;
    logic [WIDTH-1:0] bits;
    logic             set_w;

    alu_ctrl_dec u_dec (
        .op_i   (op_i),
        .ctrl_o (ctl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic cin_w;
        logic less_w;
        logic res_w;
        logic sum_w;
        logic cout_w;

        if (i == 0) begin : g_lsb
            assign cin_w  = ctl.bneg;
            assign less_w = set_w;
        end else begin : g_upper
            assign cin_w  = g_slice[i-1].cout_w;
            assign less_w = 1'b0;
        end

        alu_bit_slice u_bit (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .ainv_i (ctl.ainv),
            .bneg_i (ctl.bneg),
            .sel_i  (ctl.sel),
            .cin_i  (cin_w),
            .less_i (less_w),
            .res_o  (res_w),
            .sum_o  (sum_w),
            .cout_o (cout_w)
        );

        assign bits[i] = res_w;
    end

    // Sign of A-B corrected by the overflow of the top slice.
    assign set_w = g_slice[MSB].sum_w ^ (g_slice[MSB].cin_w ^ g_slice[MSB].cout_w);

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .ctrl_i     (ctl),
        .bits_i     (bits),
        .top_cin_i  (g_slice[MSB].cin_w),
        .top_cout_i (g_slice[MSB].cout_w),
        .result_o   (result_o),
        .carry_o    (carry_o),
        .ovf_o      (ovf_o),
        .zero_o     (zero_o)
    );

endmodule

// File: rtl/bitslice_alu_props.sv
module bitslice_alu_props
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             ovf_o,
    input logic             zero_o
);

    localparam int MSB = WIDTH - 1;

    logic is_logic;
    logic is_known;

    assign is_logic = (op_i == OPC_AND) || (op_i == OPC_OR) || (op_i == OPC_NOR);
    assign is_known = is_logic || (op_i == OPC_ADD) || (op_i == OPC_SUB) || (op_i == OPC_SLT);

    always_comb begin
        if (is_logic) begin
            p_logic_quiet_r1: assert (!carry_o && !ovf_o);
        end
        if (op_i == OPC_ADD && ovf_o) begin
            p_add_ovf_signs_r4: assert (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]);
        end
        if (op_i == OPC_SUB && ovf_o) begin
            p_sub_ovf_signs_r5: assert (a_i[MSB] != b_i[MSB] && result_o[MSB] != a_i[MSB]);
        end
        if (op_i == OPC_SLT) begin
            p_slt_upper_clear_r6: assert (result_o[MSB:1] == '0);
        end
        if (zero_o) begin
            p_zero_means_clear_r8: assert (result_o == '0);
        end
        if (!is_known) begin
            p_undef_quiet_r9: assert (result_o == '0 && !ovf_o && !carry_o && zero_o);
        end
    end

endmodule

bind bitslice_alu bitslice_alu_props #(.WIDTH(WIDTH)) u_props (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o),
    .zero_o   (zero_o)
);

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   op;
    logic [W-1:0] result;
    logic         carry;
    logic         ovf;
    logic         zero;

    int checks = 0;
    int errors = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitslice_alu u_bitslice_alu (
        .a_i      (a),
        .b_i      (b),
        .op_i     (op),
        .result_o (result),
        .carry_o  (carry),
        .ovf_o    (ovf),
        .zero_o   (zero)
    );

    task automatic model(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y,
                         output logic [W-1:0] r, output logic co, output logic ov);
        logic [W:0] s;
        r = '0; co = 1'b0; ov = 1'b0;
        case (c)
            4'b0000: r = x & y;
            4'b0001: r = x | y;
            4'b1100: r = ~(x | y);
            4'b0010: begin
                s = {1'b0, x} + {1'b0, y};
                r = s[W-1:0]; co = s[W];
                ov = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
            end
            4'b0110, 4'b0111: begin
                r = x - y; co = (x >= y);
                ov = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
                if (c == 4'b0111) r = ($signed(x) < $signed(y)) ? 1 : 0;
            end
            default: begin r = '0; co = 1'b0; ov = 1'b0; end
        endcase
    endtask

    task automatic apply(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y,
                         input string req);
        logic [W-1:0] er;
        logic eco, eov, ez;
        @(posedge clk);
        op = c; a = x; b = y;
        @(negedge clk);
        model(c, x, y, er, eco, eov);
        ez = (er == '0);
        checks++;
        if (result !== er || carry !== eco || ovf !== eov || zero !== ez) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h actual res=%h c=%b v=%b z=%b expected res=%h c=%b v=%b z=%b",
                     req, c, x, y, result, carry, ovf, zero, er, eco, eov, ez);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic t_reset_state();
        apply(4'b0000, '0, '0, "R8 idle zero");
    endtask

    task automatic t_logic();
        apply(4'b0000, 32'hF0F0_1234, 32'hFF00_FF00, "R1 and");
        apply(4'b0001, 32'hF0F0_1234, 32'h0F00_0001, "R1 or");
        apply(4'b0000, 32'hAAAA_AAAA, 32'h5555_5555, "R1 and zero R8");
    endtask

    task automatic t_nor();
        apply(4'b1100, 32'h0000_FFFF, 32'h00FF_0000, "R2 nor");
        apply(4'b1100, 32'hFFFF_FFFF, 32'h0, "R2 nor zero");
    endtask

    task automatic t_add();
        apply(4'b0010, 32'd5, 32'd7, "R3 add");
        apply(4'b0010, 32'hFFFF_FFFF, 32'd1, "R3 carry R8");
        apply(4'b0010, 32'h7FFF_FFFF, 32'd1, "R4 pos ovf");
        apply(4'b0010, 32'h8000_0000, 32'h8000_0000, "R4 neg ovf");
        apply(4'b0010, 32'h7FFF_FFFF, 32'h8000_0000, "R4 mixed no ovf");
    endtask

    task automatic t_sub();
        apply(4'b0110, 32'd9, 32'd9, "R5 equal R8");
        apply(4'b0110, 32'd3, 32'd4, "R5 borrow");
        apply(4'b0110, 32'h8000_0000, 32'd1, "R5 ovf");
        apply(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5 ovf neg b");
    endtask

    task automatic t_slt();
        apply(4'b0111, 32'hFFFF_FFFF, 32'd1, "R6 neg lt pos");
        apply(4'b0111, 32'd1, 32'hFFFF_FFFF, "R6 pos gt neg");
        apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF, "R6 ovf lt R7");
        apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000, "R6 ovf gt R7");
        apply(4'b0111, 32'd42, 32'd42, "R6 equal");
    endtask

    task automatic t_undef();
        for (int c = 0; c < 16; c++) begin
            if (c != 0 && c != 1 && c != 2 && c != 6 && c != 7 && c != 12)
                apply(4'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9 undefined");
        end
    endtask

    task automatic t_random();
        logic [3:0] codes [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] x;
            lfsr = step(lfsr); x = lfsr;
            lfsr = step(lfsr);
            apply(codes[n % 6], x, lfsr, "R3 R5 R6 R7 random");
        end
    endtask

    initial begin
        a = '0; b = '0; op = '0;
        repeat (2) @(posedge clk);
        t_reset_state();
        t_logic();
        t_nor();
        t_add();
        t_sub();
        t_slt();
        t_undef();
        t_random();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule